// File: doc/BRIEF.md
# Predicated Complex Add-Rotate Unit

This block performs a rotated complex addition across a 128-bit vector. Adjacent lanes form complex pairs, with the real part in the even lane and the imaginary part in the odd lane. The first source is added to the second source after that source is turned by 90 or 270 degrees in the complex plane. A 90-degree turn maps (re, im) to (-im, re). A 270-degree turn maps it to (im, -re). Lanes can be 8, 16 or 32 bits wide.

The unit computes every lane from the unmodified source inputs before any merge takes place. A per-byte predicate then blends the new lane bytes with the previous destination value. The merged vector is registered with one cycle of latency. Callers may therefore feed the old destination from the same register as the second source, and the result is still correct. The size code 3 is reserved. For that code the unit returns the old destination unchanged and raises an error flag.

Top module: `cxr_addrot`

## Requirements
- R1: With `elem_size`=0 (8-bit lanes, 16 lanes) and `rot_sel`=0, even lane e yields n[e]-m[e+1] and odd lane e yields n[e]+m[e-1]. Lane 0 occupies bits [7:0].
- R2: With `rot_sel`=1, even lane e yields n[e]+m[e+1] and odd lane e yields n[e]-m[e-1]. This holds at every legal size.
- R3: `elem_size`=1 selects 16-bit lanes (8 lanes) and `elem_size`=2 selects 32-bit lanes (4 lanes). Each uses the same pairing as R1/R2.
- R4: Addition and subtraction wrap modulo 2^lane width. There is no saturation and no carry or borrow across lane boundaries.
- R5: `byte_pred` bit k controls result bits [8k+7:8k]. A 1 takes the new byte and a 0 keeps the byte of `dst_old`. An all-zero predicate returns `dst_old` exactly.
- R6: Every lane uses the original source values. When `dst_old` equals `src_m` (the destination aliases the second source), the result still matches R1–R3 at every size, including 32-bit.
- R7: With `elem_size`=3 and `in_valid`=1, the next cycle shows `size_err`=1 and `result` equal to `dst_old`. For any legal size, `size_err`=0.
- R8: `out_valid` equals `in_valid` delayed by one clock. `result` and `size_err` update on that same edge. A synchronous active-high reset clears `out_valid`, `size_err` and `result`.
- R9: While `in_valid` is 0, `result` and `size_err` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_n | input | 128 | First source vector |
| src_m | input | 128 | Second source vector, the one that is rotated |
| dst_old | input | 128 | Previous destination value |
| byte_pred | input | 16 | Per-byte write predicate |
| elem_size | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: reserved |
| rot_sel | input | 1 | 0: 90 degrees, 1: 270 degrees |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| result | output | 128 | Merged destination vector |
| size_err | output | 1 | Reserved size code seen |

## Verification
The bench applies random sources with random predicates under each of the three sizes and both rotations. A wrong lane pairing, a swapped add/subtract or a size mix-up therefore shows up quickly. Directed vectors cover several cases:
- borrows at the lane edges, which separate true modulo wrap from carries leaking across lanes;
- all-zero and all-one predicates, which separate a missing merge from an inverted one;
- a destination equal to the second source, which confirms that results come from unmodified inputs;
- the reserved size code.

Idle gaps and back-to-back strobes check the one-cycle latency and that the outputs hold while idle.

// File: rtl/cxr_pkg.sv
package cxr_pkg;

  localparam int VEC_W   = 128;
  localparam int BYTES   = VEC_W / 8;
  localparam int N_SIZES = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } elem_sz_e;

  // Lane width in bits for a legal size index.
  function automatic int lane_bits(input int sz);
    return 8 << sz;
  endfunction

  // Partner lane of a complex pair: even lanes read the next lane,
  // odd lanes read the previous one.
  function automatic int partner_of(input int lane);
    return lane ^ 1;
  endfunction

  // Subtract when the lane is real and rotation is 90, or the lane
  // is imaginary and rotation is 270.
  function automatic logic lane_subtracts(input int lane, input logic rot270);
    logic is_real;
    is_real = ((lane % 2) == 0);
    return is_real ^ rot270;
  endfunction

  // Legal size test on the raw code.
  function automatic logic size_legal(input logic [1:0] code);
    return code != SZ_RSVD;
  endfunction

endpackage

// File: rtl/cxr_lane_bank.sv
module cxr_lane_bank
  import cxr_pkg::*;
#(
  parameter int VW     = 128,
  parameter int LANE_W = 8
) (
  input  logic [VW-1:0] vec_n,
  input  logic [VW-1:0] vec_m,
  input  logic          rot270,
  output logic [VW-1:0] vec_r
);

  localparam int LANES = VW / LANE_W;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    localparam int P = partner_of(e);
    localparam logic SUB90 = lane_subtracts(e, 1'b0);

    logic [LANE_W-1:0] a_op;
    logic [LANE_W-1:0] b_op;
    logic [LANE_W-1:0] lane_sum;
    logic [LANE_W-1:0] lane_dif;
    logic              do_sub;

    assign a_op     = vec_n[e*LANE_W +: LANE_W];
    assign b_op     = vec_m[P*LANE_W +: LANE_W];
    assign lane_sum = a_op + b_op;
    assign lane_dif = a_op - b_op;
    assign do_sub   = SUB90 ^ rot270;
    assign vec_r[e*LANE_W +: LANE_W] = do_sub ? lane_dif : lane_sum;
  end

endmodule

// File: rtl/cxr_byte_merge.sv
module cxr_byte_merge #(
  parameter int NB = 16
) (
  input  logic [8*NB-1:0] fresh,
  input  logic [8*NB-1:0] prior,
  input  logic [NB-1:0]   keep_n,
  output logic [8*NB-1:0] merged
);

  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign merged[8*k +: 8] = keep_n[k] ? fresh[8*k +: 8] : prior[8*k +: 8];
  end

endmodule

// File: rtl/cxr_addrot.sv
module cxr_addrot
  import cxr_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [127:0]   src_n,
  input  logic [127:0]   src_m,
  input  logic [127:0]   dst_old,
  input  logic [15:0]    byte_pred,
  input  logic [1:0]     elem_size,
  input  logic           rot_sel,
  output logic           out_valid,
  output logic [127:0]   result,
  output logic           size_err
);

  // Per-size raw lane results, all computed from the unmodified inputs.
  logic [VEC_W-1:0] bank_res [N_SIZES];

  for (genvar s = 0; s < N_SIZES; s++) begin : g_size
    cxr_lane_bank #(
      .VW    (VEC_W),
      .LANE_W(lane_bits(s))
    ) u_bank (
      .vec_n (src_n),
      .vec_m (src_m),
      .rot270(rot_sel),
      .vec_r (bank_res[s])
    );
  end

  // Named internal events for the checks.
  logic             size_bad;
  logic [VEC_W-1:0] lane_pick;
  logic [VEC_W-1:0] merge_out;
  logic [VEC_W-1:0] next_res;

  assign size_bad = !size_legal(elem_size);

  always_comb begin
    unique case (elem_size)
      SZ_HALF: lane_pick = bank_res[1];
      SZ_WORD: lane_pick = bank_res[2];
      default: lane_pick = bank_res[0];
    endcase
  end

  cxr_byte_merge #(.NB(BYTES)) u_merge (
    .fresh (lane_pick),
    .prior (dst_old),
    .keep_n(byte_pred),
    .merged(merge_out)
  );

  assign next_res = size_bad ? dst_old : merge_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      size_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= next_res;
        size_err <= size_bad;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  rsvd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && elem_size == 2'd3) |=> (size_err && result == $past(dst_old)));

  // R7
  legal_noerr_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && elem_size != 2'd3) |=> !size_err);

  // R5
  zero_pred_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && byte_pred == 16'h0) |=> (result == $past(dst_old)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(size_err)));

endmodule

// File: tb/cxr_addrot_test.sv
`timescale 1ns/1ps
module cxr_addrot_test;

  typedef struct {
    logic [127:0] res;
    logic         err;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] src_n, src_m, dst_old;
  logic [15:0]  byte_pred;
  logic [1:0]   elem_size;
  logic         rot_sel;
  logic         out_valid;
  logic [127:0] result;
  logic         size_err;

  int total = 0;
  int bad   = 0;
  exp_t sb[$];
  logic [127:0] last_res = '0;
  logic         last_err = 1'b0;
  bit           done = 0;

  always #2 clk = ~clk;

  cxr_addrot uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .src_n(src_n), .src_m(src_m), .dst_old(dst_old),
    .byte_pred(byte_pred), .elem_size(elem_size), .rot_sel(rot_sel),
    .out_valid(out_valid), .result(result), .size_err(size_err)
  );

  // Behavioural reference: each lane is taken as an unsigned number,
  // its partner is fetched by index, and the sum is reduced modulo 2^w.
  function automatic logic [127:0] model(input logic [127:0] n, input logic [127:0] m,
                                         input logic [127:0] d, input logic [15:0] p,
                                         input int sz, input bit rot);
    logic [127:0] raw;
    logic [127:0] o;
    longint unsigned modv, a, b, v;
    int w, cnt, partner;
    raw = '0;
    if (sz == 3) return d;
    w = 8 * (1 << sz);
    cnt = 128 / w;
    modv = 64'd1 << w;
    for (int e = 0; e < cnt; e++) begin
      partner = (e % 2 == 0) ? e + 1 : e - 1;
      a = 0; b = 0;
      for (int i = 0; i < w; i++) begin
        a[i] = n[e*w + i];
        b[i] = m[partner*w + i];
      end
      if ((e % 2 == 0) != rot) v = (a + modv - b) % modv;
      else                     v = (a + b) % modv;
      for (int i = 0; i < w; i++) raw[e*w + i] = v[i];
    end
    for (int k = 0; k < 16; k++)
      o[8*k +: 8] = p[k] ? raw[8*k +: 8] : d[8*k +: 8];
    return o;
  endfunction

  task automatic send(input logic [127:0] n, input logic [127:0] m, input logic [127:0] d,
                      input logic [15:0] p, input int sz, input bit rot, input string tag);
    exp_t x;
    @(negedge clk);
    in_valid  = 1'b1;
    src_n     = n;
    src_m     = m;
    dst_old   = d;
    byte_pred = p;
    elem_size = sz[1:0];
    rot_sel   = rot;
    x.res = model(n, m, d, p, sz, rot);
    x.err = (sz == 3);
    x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_n = {4{$urandom}};
      src_m = {4{$urandom}};
      dst_old = {4{$urandom}};
      byte_pred = 16'($urandom);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // Monitor: pops expected items as results appear.
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #1;
      if (!rst && out_valid) begin
        total++;
        if (sb.size() == 0) begin
          bad++;
          $display("FAIL R8: out_valid=%0d expected=0 (no pending operation)", out_valid);
        end else begin
          x = sb.pop_front();
          if (result !== x.res || size_err !== x.err) begin
            bad++;
            $display("FAIL %s: result=%h err=%0d expected result=%h err=%0d",
                     x.tag, result, size_err, x.res, x.err);
          end
          last_res = x.res;
          last_err = x.err;
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: finished=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0;
    src_n = '0; src_m = '0; dst_old = '0; byte_pred = '0; elem_size = '0; rot_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    total++;
    if (out_valid !== 1'b0 || size_err !== 1'b0 || result !== '0) begin
      bad++;
      $display("FAIL R8: reset v=%0d err=%0d res=%h expected 0 0 0", out_valid, size_err, result);
    end

    // R1: simple 8-bit 90-degree pattern
    send({16{8'h10}}, {8{8'h03, 8'h01}}, '0, 16'hFFFF, 0, 0, "R1");
    // R2: same data, 270 degrees
    send({16{8'h10}}, {8{8'h03, 8'h01}}, '0, 16'hFFFF, 0, 1, "R2");
    // R4: borrow/overflow at lane edges, all sizes
    send('0, {16{8'hFF}}, '0, 16'hFFFF, 0, 0, "R4");
    send({8{16'hFFFF}}, {8{16'h0001}}, '0, 16'hFFFF, 1, 1, "R4");
    send({4{32'h0000_0000}}, {4{32'h0000_0001}}, '0, 16'hFFFF, 2, 0, "R4");
    send({4{32'hFFFF_FFFF}}, {4{32'h0000_0002}}, '0, 16'hFFFF, 2, 1, "R4");
    idle(2);
    // R5: predicate edges
    send(rnd128(), rnd128(), rnd128(), 16'h0000, 1, 0, "R5");
    send(rnd128(), rnd128(), rnd128(), 16'hFFFF, 1, 1, "R5");
    send(rnd128(), rnd128(), rnd128(), 16'hA5C3, 2, 0, "R5");
    // R6: destination aliases second source
    for (int s = 0; s < 3; s++) begin
      logic [127:0] mm;
      mm = rnd128();
      send(rnd128(), mm, mm, 16'hFFFF, s, s % 2, "R6");
      send(rnd128(), mm, mm, 16'($urandom), s, 1 - s % 2, "R6");
    end
    // R7: reserved size
    send(rnd128(), rnd128(), 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 16'hFFFF, 3, 0, "R7");
    send(rnd128(), rnd128(), rnd128(), 16'h1234, 3, 1, "R7");
    send(rnd128(), rnd128(), rnd128(), 16'hFFFF, 0, 0, "R7");
    idle(1);

    // R9: outputs hold while idle
    idle(4);
    total++;
    if (result !== last_res || size_err !== last_err) begin
      bad++;
      $display("FAIL R9: res=%h err=%0d expected res=%h err=%0d", result, size_err, last_res, last_err);
    end

    // R1 R2 R3: random sweep over sizes and rotations
    for (int s = 0; s < 3; s++) begin
      for (int r = 0; r < 2; r++) begin
        for (int i = 0; i < 30; i++) begin
          logic [15:0] pp;
          pp = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF : 16'($urandom);
          send(rnd128(), rnd128(), rnd128(), pp, s, r[0],
               s == 0 ? (r == 0 ? "R1" : "R2") : "R3");
          if (i % 7 == 3) idle(1);
        end
      end
    end
    idle(3);
    // R8: nothing left unanswered
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R8: pending=%0d expected=0", sb.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule